// File: doc/BRIEF.md
# Repeat-Mode DMA Address Sequencer

This block keeps the memory-side address and the transfer count for one DMA channel that runs in repeat mode. Each transfer completed on the channel moves the memory address by one element and takes one from a down-counting transfer counter. The element is a byte or a word, and the address moves either up or down. When the transfer that empties the counter completes, the counter is refilled from a block-length holding register. In that same cycle the memory address rewinds to the first address of the block. The channel then repeats the same block for as long as its enable input stays high. Reaching the end of a block raises no interrupt. A one-cycle wrap pulse is provided for observation only.

Software programs the start address, the counter, the holding register and a fixed peripheral-side address. It does this while the channel is disabled, and normally writes the same value to the counter and to the holding register. When the enable input is dropped, the channel stops where it is. When the enable input is raised again, the channel carries on from the next transfer of the same block. Nothing is reinitialised on re-enable. Bus cycles, request arbitration and data movement belong to neighbouring logic.

Top module: `rpt_dma_seq`

## Requirements
- R1: After reset, memAddr, xferCount, reloadVal and periphAddr are all zero, and blockWrap is low.
- R2: A write strobe (wrAddr, wrCount, wrReload or wrPeriph) loads its register from wrData only while chanEn is low. wrCount and wrReload take the low 8 bits of wrData. Write strobes that arrive while chanEn is high change nothing.
- R3: A completed transfer (xferDone high while chanEn is high) moves memAddr by a step. The step is +1 with sizeWord=0 and dirDown=0, +2 with sizeWord=1 and dirDown=0, −1 with sizeWord=0 and dirDown=1, and −2 with sizeWord=1 and dirDown=1. The address arithmetic wraps modulo 2^24.
- R4: A completed transfer with xferCount not equal to 1 lowers xferCount by exactly one. A value of 0 decrements to 255.
- R5: A completed transfer with xferCount equal to 1 loads xferCount from reloadVal. In the same cycle it sets memAddr to its old value plus step minus step·reloadVal, which returns the address to the start of the block.
- R6: blockWrap is high for exactly the one cycle that follows each reload edge, and is low after every other edge.
- R7: xferDone pulses while chanEn is low leave memAddr, xferCount and blockWrap unchanged.
- R8: After chanEn is dropped and raised again, the next transfer continues from the held address and count. The result is the same sequence as a run with no pause.
- R9: periphAddr changes only through its own write and is unaffected by transfers and wraps.
- R10: A reloadVal of 0 stands for a block of 256 transfers, so the rewind subtracts step·256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel enable (run while high) |
| xferDone | input | 1 | One transfer completed this cycle |
| sizeWord | input | 1 | 0 = byte step, 1 = word step |
| dirDown | input | 1 | 0 = address counts up, 1 = down |
| wrAddr | input | 1 | Load memory address from wrData |
| wrCount | input | 1 | Load transfer counter from wrData[7:0] |
| wrReload | input | 1 | Load block length from wrData[7:0] |
| wrPeriph | input | 1 | Load peripheral address from wrData |
| wrData | input | 24 | Write data |
| memAddr | output | 24 | Current memory address |
| xferCount | output | 8 | Transfers left in the block |
| reloadVal | output | 8 | Block length holding register |
| periphAddr | output | 24 | Fixed peripheral-side address |
| blockWrap | output | 1 | One-cycle pulse on each reload |

## Verification
The stepping and rewind are swept over all four combinations of size and direction. Each combination runs with block lengths of 1, 2, 3 and 5, from one start address just above zero and one just below 2^24. Running several blocks back to back separates a correct rewind from an off-by-one-step rewind, and shows whether the address wraps modulo 2^24 in both directions. A length of 1 makes every transfer a reload. A reload value of 0 exercises the 256-transfer block. A run broken by disabled gaps is compared against the uninterrupted arithmetic, with stray transfer pulses and writes placed inside and outside the gaps.

// File: rtl/rpt_dma_pkg.sv
package rpt_dma_pkg;
  typedef struct packed {
    logic advance;
    logic wrap;
    logic ldAddr;
    logic ldCount;
    logic ldReload;
    logic ldPeriph;
  } seqCtl_t;
endpackage

// File: rtl/rpt_dma_ctl.sv
module rpt_dma_ctl
  import rpt_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chanEn,
  input  logic    xferDone,
  input  logic    wrAddr,
  input  logic    wrCount,
  input  logic    wrReload,
  input  logic    wrPeriph,
  input  logic    lastXfer,
  output seqCtl_t ctl,
  output logic    blockWrap
);
  logic idle;

  always_comb begin
    idle         = !chanEn;
    ctl.advance  = chanEn && xferDone;
    ctl.wrap     = chanEn && xferDone && lastXfer;
    ctl.ldAddr   = idle && wrAddr;
    ctl.ldCount  = idle && wrCount;
    ctl.ldReload = idle && wrReload;
    ctl.ldPeriph = idle && wrPeriph;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blockWrap <= 1'b0;
    else       blockWrap <= ctl.wrap;
  end
endmodule

// File: rtl/rpt_dma_dp.sv
module rpt_dma_dp
  import rpt_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              sizeWord,
  input  logic              dirDown,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [ADDR_W-1:0] periphAddr,
  output logic              lastXfer
);
  localparam int LEN_W = CNT_W + 1;
  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] stepMag;
  logic [LEN_W-1:0]  blockLen;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    stepMag  = sizeWord ? ADDR_W'(2) : ADDR_W'(1);
    blockLen = (reloadVal == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, reloadVal};
    span     = {{PAD_W{1'b0}}, blockLen} << sizeWord;
    stepped  = dirDown ? (memAddr - stepMag) : (memAddr + stepMag);
    if (ctl.wrap) nextAddr = dirDown ? (stepped + span) : (stepped - span);
    else          nextAddr = stepped;
    lastXfer = (xferCount == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr    <= '0;
      xferCount  <= '0;
      reloadVal  <= '0;
      periphAddr <= '0;
    end else begin
      if (ctl.ldAddr)       memAddr <= wrData;
      else if (ctl.advance) memAddr <= nextAddr;

      if (ctl.ldCount)      xferCount <= wrData[CNT_W-1:0];
      else if (ctl.wrap)    xferCount <= reloadVal;
      else if (ctl.advance) xferCount <= xferCount - CNT_W'(1);

      if (ctl.ldReload) reloadVal  <= wrData[CNT_W-1:0];
      if (ctl.ldPeriph) periphAddr <= wrData;
    end
  end
endmodule

// File: rtl/rpt_dma_seq.sv
module rpt_dma_seq
  import rpt_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              xferDone,
  input  logic              sizeWord,
  input  logic              dirDown,
  input  logic              wrAddr,
  input  logic              wrCount,
  input  logic              wrReload,
  input  logic              wrPeriph,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [ADDR_W-1:0] periphAddr,
  output logic              blockWrap
);
  seqCtl_t ctl;
  logic    lastXfer;

  rpt_dma_ctl u_ctl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferDone(xferDone),
    .wrAddr(wrAddr), .wrCount(wrCount), .wrReload(wrReload), .wrPeriph(wrPeriph),
    .lastXfer(lastXfer), .ctl(ctl), .blockWrap(blockWrap)
  );

  rpt_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sizeWord(sizeWord), .dirDown(dirDown),
    .wrData(wrData), .memAddr(memAddr), .xferCount(xferCount),
    .reloadVal(reloadVal), .periphAddr(periphAddr), .lastXfer(lastXfer)
  );
endmodule

// File: rtl/rpt_dma_seq_chk.sv
module rpt_dma_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEn,
  input logic              xferDone,
  input logic              sizeWord,
  input logic              dirDown,
  input logic              wrAddr,
  input logic              wrCount,
  input logic              wrReload,
  input logic              wrPeriph,
  input logic [ADDR_W-1:0] memAddr,
  input logic [CNT_W-1:0]  xferCount,
  input logic [CNT_W-1:0]  reloadVal,
  input logic [ADDR_W-1:0] periphAddr,
  input logic              blockWrap
);
  AST_ENABLED_WRITES_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !xferDone) |=> ($stable(memAddr) && $stable(xferCount) && $stable(reloadVal))); // R2

  AST_DISABLED_XFER_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && !wrAddr && !wrCount) |=> ($stable(memAddr) && $stable(xferCount) && !blockWrap)); // R7

  AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && xferDone && xferCount != CNT_W'(1)) |=>
      (xferCount == $past(xferCount) - CNT_W'(1) && !blockWrap)); // R4

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && xferDone && xferCount == CNT_W'(1)) |=> blockWrap); // R6

  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    blockWrap |-> (xferCount == reloadVal)); // R5

  AST_PERIPH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wrPeriph |=> $stable(periphAddr)); // R9

  AST_UP_BYTE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && xferDone && xferCount != CNT_W'(1) && !sizeWord && !dirDown) |=>
      (memAddr == $past(memAddr) + ADDR_W'(1))); // R3
endmodule

bind rpt_dma_seq rpt_dma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferDone(xferDone),
  .sizeWord(sizeWord), .dirDown(dirDown), .wrAddr(wrAddr), .wrCount(wrCount),
  .wrReload(wrReload), .wrPeriph(wrPeriph), .memAddr(memAddr),
  .xferCount(xferCount), .reloadVal(reloadVal), .periphAddr(periphAddr),
  .blockWrap(blockWrap)
);

// File: tb/rpt_dma_seq_bench.sv
module rpt_dma_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanEn = 1'b0, xferDone = 1'b0, sizeWord = 1'b0, dirDown = 1'b0;
  logic        wrAddr = 1'b0, wrCount = 1'b0, wrReload = 1'b0, wrPeriph = 1'b0;
  logic [23:0] wrData = '0;
  logic [23:0] memAddr, periphAddr;
  logic [7:0]  xferCount, reloadVal;
  logic        blockWrap;

  int vecs = 0;
  int errs = 0;
  int expAddr, expCnt, expRel;
  logic expWrap;

  rpt_dma_seq u_rpt_dma_seq (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferDone(xferDone),
    .sizeWord(sizeWord), .dirDown(dirDown), .wrAddr(wrAddr), .wrCount(wrCount),
    .wrReload(wrReload), .wrPeriph(wrPeriph), .wrData(wrData),
    .memAddr(memAddr), .xferCount(xferCount), .reloadVal(reloadVal),
    .periphAddr(periphAddr), .blockWrap(blockWrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write one register (0 addr, 1 count, 2 reload, 3 periph)
  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wrData   = data[23:0];
    wrAddr   = (sel == 0);
    wrCount  = (sel == 1);
    wrReload = (sel == 2);
    wrPeriph = (sel == 3);
    @(negedge clk);
    wrAddr = 0; wrCount = 0; wrReload = 0; wrPeriph = 0;
  endtask

  function automatic int stepOf();
    int s = sizeWord ? 2 : 1;
    return dirDown ? -s : s;
  endfunction

  // one completed transfer; model and compare
  task automatic xfer(input string tagA);
    int len;
    @(negedge clk);
    xferDone = 1;
    @(negedge clk);
    xferDone = 0;
    expAddr = expAddr + stepOf();
    expWrap = 0;
    if (expCnt == 1) begin
      len = (expRel == 0) ? 256 : expRel;
      expAddr = expAddr - stepOf() * len;
      expCnt  = expRel;
      expWrap = 1;
    end else begin
      expCnt = (expCnt + 255) & 8'hFF;
    end
    expAddr = expAddr & 24'hFFFFFF;
    chk(expWrap ? {tagA, " R5 addr rewind"} : {tagA, " R3 addr step"}, int'(memAddr), expAddr);
    chk(expWrap ? "R5 count reload" : "R4 count decrement", int'(xferCount), expCnt);
    chk("R6 wrap pulse", int'(blockWrap), int'(expWrap));
  endtask

  task automatic setup(input int start, input int n);
    chanEn = 0;
    wr(0, start); wr(1, n); wr(2, n);
    expAddr = start; expCnt = n; expRel = n;
  endtask

  initial begin
    int lens[4] = '{1, 2, 3, 5};
    int starts[2] = '{24'h000001, 24'hFFFFFE};
    repeat (3) @(negedge clk);
    chk("R1 addr reset", int'(memAddr), 0);
    chk("R1 count reset", int'(xferCount), 0);
    chk("R1 reload reset", int'(reloadVal), 0);
    chk("R1 periph reset", int'(periphAddr), 0);
    chk("R1 wrap reset", int'(blockWrap), 0);
    rstN = 1;
    @(negedge clk);

    wr(3, 24'h00ABCD);
    chk("R2 periph write", int'(periphAddr), 24'h00ABCD);

    // sweep size x direction x length x start
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int li = 0; li < 4; li++) begin
        for (int si = 0; si < 2; si++) begin
          sizeWord = cfg[0];
          dirDown  = cfg[1];
          setup(starts[si], lens[li]);
          chk("R2 addr write", int'(memAddr), starts[si]);
          chk("R2 reload write", int'(reloadVal), lens[li]);
          @(negedge clk); chanEn = 1;
          for (int t = 0; t < 2 * lens[li] + 1; t++) xfer("sweep");
        end
      end
    end
    chk("R9 periph held", int'(periphAddr), 24'h00ABCD);

    // R10: reload 0 => 256-transfer block
    sizeWord = 1; dirDown = 0;
    setup(24'h001000, 0);
    @(negedge clk); chanEn = 1;
    for (int t = 0; t < 257; t++) xfer("R10");
    chk("R10 back at start+step", int'(memAddr), 24'h001002);

    // R8 / R7 / R2: pause, stray pulses and writes
    sizeWord = 0; dirDown = 1;
    setup(24'h000200, 4);
    @(negedge clk); chanEn = 1;
    xfer("R8 pre");
    // writes while enabled are ignored
    wr(0, 24'h123456); wr(1, 8'h77); wr(2, 8'h66); wr(3, 24'h654321);
    chk("R2 addr ignored", int'(memAddr), expAddr);
    chk("R2 count ignored", int'(xferCount), expCnt);
    chk("R2 reload ignored", int'(reloadVal), expRel);
    chk("R2 periph ignored", int'(periphAddr), 24'h00ABCD);
    xfer("R8 pre2");
    @(negedge clk); chanEn = 0;
    @(negedge clk); xferDone = 1;
    repeat (3) @(negedge clk);
    xferDone = 0;
    chk("R7 addr unchanged", int'(memAddr), expAddr);
    chk("R7 count unchanged", int'(xferCount), expCnt);
    chk("R7 no wrap", int'(blockWrap), 0);
    @(negedge clk); chanEn = 1;
    for (int t = 0; t < 7; t++) xfer("R8 resume");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule